// File: doc/BRIEF.md
# Cascaded Modulo Counter with Terminal Count

This block is an 8-bit synchronous counter made from two identical 4-bit modulo-16 stages. Each stage can clear, load a parallel value, count up by one, or hold. It raises a terminal-count flag when it holds its top value and is enabled to count. The low stage is enabled by the block's count enable. The high stage is enabled only by the low stage's terminal count, so both stages together count modulo 256. Both stages use the same clock edge, so there is no ripple between them.

Clear and load reach both stages in the same cycle and override counting. A range mode, selected by an input, turns the block into a bounded counter. When counting is enabled and the count equals a parameterised upper bound, the block reloads a parameterised lower bound instead of incrementing. It then cycles from the lower bound through the upper bound and back. The defaults are 5 and 11. A modulo-m counter is the special case where the lower bound is 0 and the upper bound is m-1.

Top module: `casc_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0 and `tc` is 0.
- R2: When `clr` is 1 at a clock edge, `count` becomes 0, whatever `ld`, `cnt_en` and `range_en` are.
- R3: When `ld` is 1 and `clr` is 0 at a clock edge, `count` becomes `ld_val`, whatever `cnt_en` is.
- R4: When `clr`, `ld` and `cnt_en` are all 0, `count` keeps its value.
- R5: When only `cnt_en` is 1 and no range reload applies, `count` becomes (`count`+1) mod 256.
- R6: The high nibble `count[7:4]` changes on a counting edge only when the low nibble is 15. The low nibble then goes to 0 and the high nibble goes up by one, mod 16 (for example 0x0D, 0x0E, 0x0F, 0x10).
- R7: `tc` is 1 exactly when `count` is 255 and `cnt_en` is 1. It does not depend on `clr` or `ld`.
- R8: When `range_en`, `cnt_en` are 1, `clr`, `ld` are 0 and `count` equals RANGE_HI (default 11), the next `count` is RANGE_LO (default 5).
- R9: With `range_en` at 0, `count` passes RANGE_HI by incrementing normally.
- R10: An external load (`ld`=1) takes priority over the range reload in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of both stages |
| ld | input | 1 | Synchronous parallel load of `ld_val` |
| cnt_en | input | 1 | Count enable of the low stage |
| range_en | input | 1 | Enables the bounded RANGE_LO..RANGE_HI mode |
| ld_val | input | 8 | Parallel load value |
| count | output | 8 | Current count; high nibble from the upper stage |
| tc | output | 1 | Terminal count of the whole chain |

## Verification
The two functions that can fall in the same cycle are the carry into the high stage and an external load or clear. The bench also forces a range reload together with an external load. To provoke the first case, it holds the low nibble at 15 with `cnt_en` high and asserts `ld` or `clr` on that edge. To provoke the second, it asserts `ld` with `range_en` set while the count sits at the upper bound. A behavioural reference model applies the priority clear, then load, then range reload, then count. It is compared against `count` after every edge and against `tc` before every edge. A high nibble that advances, or a range value that appears, in place of the loaded value is reported.

// File: rtl/casc_pkg.sv
`timescale 1ns/1ps
package casc_pkg;
  localparam int unsigned STAGE_W_DEF    = 4;
  localparam int unsigned NUM_STAGES_DEF = 2;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } stage_op_e;
endpackage

// File: rtl/casc_stage.sv
`timescale 1ns/1ps
module casc_stage
  import casc_pkg::*;
#(
  parameter int unsigned SW = STAGE_W_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld,
  input  logic          en,
  input  logic [SW-1:0] d,
  output logic [SW-1:0] q,
  output logic          tc
);
  localparam logic [SW-1:0] TOP = '1;

  stage_op_e     op;
  logic [SW-1:0] q_nxt;
  logic          q_upd;

  always_comb begin
    if (clr)      op = OP_CLEAR;
    else if (ld)  op = OP_LOAD;
    else if (en)  op = OP_COUNT;
    else          op = OP_HOLD;
  end

  always_comb begin
    q_upd = 1'b1;
    case (op)
      OP_CLEAR: q_nxt = '0;
      OP_LOAD:  q_nxt = d;
      OP_COUNT: q_nxt = q + SW'(1);
      default: begin
        q_nxt = q;
        q_upd = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (q_upd) q <= q_nxt;
  end

  assign tc = en & (q == TOP);
endmodule

// File: rtl/casc_range_ctrl.sv
`timescale 1ns/1ps
module casc_range_ctrl #(
  parameter int unsigned CW       = 8,
  parameter int unsigned RANGE_LO = 5,
  parameter int unsigned RANGE_HI = 11
) (
  input  logic [CW-1:0] count,
  input  logic          cnt_en,
  input  logic          range_en,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  output logic          ld_any,
  output logic [CW-1:0] ld_data
);
  localparam logic [CW-1:0] LO_V = CW'(RANGE_LO);
  localparam logic [CW-1:0] HI_V = CW'(RANGE_HI);

  logic at_hi;

  always_comb begin
    at_hi   = range_en & cnt_en & (count == HI_V);
    ld_any  = ld | at_hi;
    ld_data = ld ? ld_val : LO_V;
  end
endmodule

// File: rtl/casc_counter.sv
`timescale 1ns/1ps
module casc_counter
  import casc_pkg::*;
#(
  parameter int unsigned SW         = STAGE_W_DEF,
  parameter int unsigned NUM_STAGES = NUM_STAGES_DEF,
  parameter int unsigned RANGE_LO   = 5,
  parameter int unsigned RANGE_HI   = 11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   ld,
  input  logic                   cnt_en,
  input  logic                   range_en,
  input  logic [SW*NUM_STAGES-1:0] ld_val,
  output logic [SW*NUM_STAGES-1:0] count,
  output logic                   tc
);
  localparam int unsigned CW = SW * NUM_STAGES;

  logic [NUM_STAGES:0] carry;
  logic                ld_any;
  logic [CW-1:0]       ld_data;

  casc_range_ctrl #(
    .CW(CW), .RANGE_LO(RANGE_LO), .RANGE_HI(RANGE_HI)
  ) u_range (
    .count(count), .cnt_en(cnt_en), .range_en(range_en),
    .ld(ld), .ld_val(ld_val), .ld_any(ld_any), .ld_data(ld_data)
  );

  assign carry[0] = cnt_en;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    casc_stage #(.SW(SW)) u_stage (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr),
      .ld   (ld_any),
      .en   (carry[g]),
      .d    (ld_data[g*SW +: SW]),
      .q    (count[g*SW +: SW]),
      .tc   (carry[g+1])
    );
  end

  assign tc = carry[NUM_STAGES];
endmodule

// File: rtl/casc_counter_chk.sv
`timescale 1ns/1ps
module casc_counter_chk #(
  parameter int unsigned CW       = 8,
  parameter int unsigned RANGE_LO = 5,
  parameter int unsigned RANGE_HI = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          ld,
  input logic          cnt_en,
  input logic          range_en,
  input logic [CW-1:0] ld_val,
  input logic [CW-1:0] count,
  input logic          tc
);
  localparam logic [CW-1:0] LO_V = CW'(RANGE_LO);
  localparam logic [CW-1:0] HI_V = CW'(RANGE_HI);
  localparam logic [CW-1:0] TOP  = '1;

  // R1
  always_comb begin
    if (!rst_n) a_r1_reset_zero: assert (count == '0);
  end

  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);

  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && ld) |=> count == $past(ld_val));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld && !cnt_en) |=> $stable(count));

  a_r5_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld && cnt_en && !(range_en && count == HI_V))
      |=> count == $past(count) + CW'(1));

  a_r7_tc_only_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (count == TOP && cnt_en));

  a_r7_tc_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (count == TOP && cnt_en) |-> tc);

  a_r8_range_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld && cnt_en && range_en && count == HI_V) |=> count == LO_V);
endmodule

bind casc_counter casc_counter_chk #(
  .CW(SW*NUM_STAGES), .RANGE_LO(RANGE_LO), .RANGE_HI(RANGE_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .ld(ld), .cnt_en(cnt_en),
  .range_en(range_en), .ld_val(ld_val), .count(count), .tc(tc)
);

// File: tb/casc_counter_bench.sv
`timescale 1ns/1ps
module casc_counter_bench;
  localparam int LO = 5;
  localparam int HI = 11;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       clr, ld, cnt_en, range_en;
  logic [7:0] ld_val;
  logic [7:0] count;
  logic       tc;

  int checks = 0;
  int errors = 0;
  int ref_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  casc_counter u_casc_counter (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ld(ld), .cnt_en(cnt_en),
    .range_en(range_en), .ld_val(ld_val), .count(count), .tc(tc)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // called at a falling edge; drives, checks tc, then count after the next edge
  task automatic step(input bit c, input bit l, input bit e, input bit r, input int v);
    int    nxt;
    string tag;
    clr = c; ld = l; cnt_en = e; range_en = r; ld_val = 8'(v);
    #1;
    check("R7", int'(tc), int'(ref_cnt == 255 && e));
    if (c) begin nxt = 0; tag = "R2"; end
    else if (l) begin
      nxt = v & 255;
      tag = (r && e && ref_cnt == HI) ? "R10" : "R3";
    end
    else if (e && r && ref_cnt == HI) begin nxt = LO; tag = "R8"; end
    else if (e) begin
      nxt = (ref_cnt + 1) % 256;
      if (!r && ref_cnt == HI) tag = "R9";
      else if ((ref_cnt % 16) == 15) tag = "R6";
      else tag = "R5";
    end
    else begin nxt = ref_cnt; tag = "R4"; end
    @(posedge clk);
    @(negedge clk);
    check(tag, int'(count), nxt);
    ref_cnt = nxt;
  endtask

  initial begin
    rst_n = 1'b0; clr = 0; ld = 0; cnt_en = 0; range_en = 0; ld_val = 0;
    repeat (3) @(negedge clk);
    check("R1", int'(count), 0);
    check("R1", int'(tc), 0);
    rst_n = 1'b1;
    @(negedge clk);
    ref_cnt = 0;

    for (int i = 0; i < 20; i++) step(0, 0, 1, 0, 0);        // R5
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0);         // R4
    step(0, 1, 0, 0, 8'h0D);                                  // R3
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0);         // R6 13,14,15,0
    step(0, 1, 1, 0, 8'hFD);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0);         // R7 wrap
    step(0, 1, 0, 0, 8'hFF);
    step(0, 0, 0, 0, 0);                                      // R7 tc low, disabled
    step(1, 1, 1, 1, 8'h77);                                  // R2 at 0xFF
    step(0, 1, 0, 0, 8'h2F);
    step(0, 1, 1, 0, 8'h40);                                  // R3 over carry
    step(0, 1, 0, 0, 8'h3F);
    step(1, 0, 1, 0, 0);                                      // R2 over carry
    step(0, 1, 0, 0, 3);
    for (int i = 0; i < 20; i++) step(0, 0, 1, 1, 0);        // R8
    step(0, 1, 0, 0, HI);
    step(0, 1, 1, 1, 8'h80);                                  // R10
    step(0, 1, 0, 0, HI);
    step(0, 0, 1, 0, 0);                                      // R9
    for (int i = 0; i < 600; i++) begin
      int   roll = $urandom_range(0, 99);
      bit   cb   = (roll < 3);
      bit   lb   = (roll >= 3 && roll < 9);
      bit   eb   = ($urandom_range(0, 9) != 0);
      bit   rb   = (i >= 300) && (i < 500);
      step(cb, lb, eb, rb, $urandom_range(0, 255));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule